// File: doc/BRIEF.md
# SPI Flash Transaction Engine

This block is a register-driven SPI master that runs one serial flash transaction each time software starts it. Software first loads a command byte, a 24-bit address and up to four data bytes into a small register file. It then writes a control byte. Enable bits in that byte pick the phases of the transaction: an optional command byte, an optional three-byte address, and a data phase of zero to four bytes that either writes to the flash or reads from it. The block shifts the bytes out in SPI mode 0, most significant bit first. It clears the busy flag in the control byte when the frame is over.

Two chip-select outputs are provided, and a control bit selects the target device. A separate override register holds one bit per chip select. Clearing a bit forces that chip select low, so several short transactions merge into one burst. A typical burst is a program command with its address, followed by a stream of command-only transactions that each carry one payload byte. The serial clock is the system clock divided by a parameter.

Top module: `spi_flash_engine`

## Requirements
- R1: Writing the control register (offset 0x8) with bit 7 set starts a transaction. Bit 7 reads 1 while the transaction runs and 0 once it has finished. Bits 6:0 read back as written.
- R2: Bytes go out in a fixed order: command, then address, then data. Each byte is shifted most significant bit first in mode 0: the serial clock idles low, MOSI changes only while the clock is low, and MISO is sampled on the rising edge.
- R3: When control bit 4 is 1, the command phase is skipped. When it is 0, the byte at offset 0x0 is sent first.
- R4: When control bit 3 is 1, three address bytes are sent, in the order offset 0x3 (bits 23:16), then 0x2 (bits 15:8), then 0x1 (bits 7:0).
- R5: Control bits 2:0 give the number of data bytes. Values 0 to 4 move that many bytes, and values 5 to 7 move four. The frame carries exactly 8 serial clocks per byte sent.
- R6: Control bit 5 sets the data direction. When it is 1, the data registers at offsets 0x4..0x7 are sent in offset order. When it is 0, 0x00 is sent and each byte received is stored in offsets 0x4, 0x5, ... in the order it arrived.
- R7: Control bit 6 selects the device. When it is 0, only cs_n[0] goes low for the frame; when it is 1, only cs_n[1] does.
- R8: Bit i of the override register (offset 0x9) drives cs_n[i]. A 0 holds that chip select low across and between transactions, with no release during the burst.
- R9: A write to the control register while a transaction is running has no effect: it changes no field and starts no further transaction.
- R10: Reads of the data registers return 0x00 while a transaction is running.
- R11: The chip select falls at least one serial clock period (2*CLK_DIV system cycles) before the first rising edge of the serial clock. It rises at least one serial clock period after the last falling edge. The serial clock toggles only inside a frame.
- R12: After reset, every register reads 0x00 except the override register, which reads 0x03. Both chip selects are high and the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 2 | Active-low chip selects, one per device |

## Verification
The assertions check several properties on every cycle: the serial clock stays low outside a byte and pulses only inside a chip-select frame, MOSI holds steady while the clock is high, no more than one chip select is active in hardware mode, and the control fields stay locked while busy. Other behaviour can only be shown by the bench scenarios. These cover the byte order for every combination of phase enables, direction, count and device, the clamping of counts above four, the bytes captured from MISO, the setup and hold gaps around each frame, and a chip select held low across a whole burst.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    localparam int REG_AW      = 4;
    localparam int ADDR_BYTES  = 3;
    localparam int DATA_BYTES  = 4;
    localparam int NUM_CS      = 2;
    localparam int FRAME_BYTES = 1 + ADDR_BYTES + DATA_BYTES;
    localparam int CNT_W       = 3;

    // control byte bit positions
    localparam int CB_DEV   = 6;
    localparam int CB_WRITE = 5;
    localparam int CB_NOCMD = 4;
    localparam int CB_ADDR  = 3;

    // register offsets
    localparam logic [REG_AW-1:0] OFS_CMD  = 4'h0;
    localparam logic [REG_AW-1:0] OFS_ADR0 = 4'h1;
    localparam logic [REG_AW-1:0] OFS_DB0  = 4'h4;
    localparam logic [REG_AW-1:0] OFS_CTRL = 4'h8;
    localparam logic [REG_AW-1:0] OFS_XCS  = 4'h9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LAUNCH,
        ST_WAIT,
        ST_HOLD
    } seq_state_e;
endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
    import spi_eng_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [REG_AW-1:0]           addr,
    input  logic [7:0]                  wdata,
    output logic [7:0]                  rdata,
    input  logic                        busy,
    input  logic                        rx_we,
    input  logic [$clog2(DATA_BYTES)-1:0] rx_idx,
    input  logic [7:0]                  rx_byte,
    output logic                        go,
    output logic [7:0]                  cmd_o,
    output logic [8*ADDR_BYTES-1:0]     addr_o,
    output logic [8*DATA_BYTES-1:0]     db_o,
    output logic [6:0]                  ctrl_o,
    output logic [NUM_CS-1:0]           xcs_o
);
    typedef struct packed {
        logic [7:0]                      cmd;
        logic [ADDR_BYTES-1:0][7:0]      adr;
        logic [DATA_BYTES-1:0][7:0]      db;
        logic [6:0]                      ctrl;
        logic [NUM_CS-1:0]               xcs;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        go  = 1'b0;
        if (wr) begin
            if (addr == OFS_CMD) r_d.cmd = wdata;
            for (int i = 0; i < ADDR_BYTES; i++)
                if (addr == REG_AW'(int'(OFS_ADR0) + i)) r_d.adr[i] = wdata;
            for (int k = 0; k < DATA_BYTES; k++)
                if (addr == REG_AW'(int'(OFS_DB0) + k)) r_d.db[k] = wdata;
            if (addr == OFS_CTRL && !busy) begin
                r_d.ctrl = wdata[6:0];
                go       = wdata[7];
            end
            if (addr == OFS_XCS) r_d.xcs = wdata[NUM_CS-1:0];
        end
        if (rx_we) r_d.db[rx_idx] = rx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.xcs <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (addr == OFS_CMD) rdata = r_q.cmd;
        for (int i = 0; i < ADDR_BYTES; i++)
            if (addr == REG_AW'(int'(OFS_ADR0) + i)) rdata = r_q.adr[i];
        for (int k = 0; k < DATA_BYTES; k++)
            if (addr == REG_AW'(int'(OFS_DB0) + k)) rdata = busy ? 8'h00 : r_q.db[k];
        if (addr == OFS_CTRL) rdata = {busy, r_q.ctrl};
        if (addr == OFS_XCS)  rdata = 8'(r_q.xcs);
    end

    assign cmd_o  = r_q.cmd;
    assign addr_o = r_q.adr;
    assign db_o   = r_q.db;
    assign ctrl_o = r_q.ctrl;
    assign xcs_o  = r_q.xcs;

    // R9: control fields frozen while a frame runs
    a_r9_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr && addr == OFS_CTRL) |=> $stable(r_q.ctrl))
        else $error("control changed while busy");
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        logic          active;
        logic          sclk;
        logic [DW-1:0] dcnt;
        logic [2:0]    bcnt;
        logic [7:0]    tx_sh;
        logic [7:0]    rx_sh;
    } sh_t;

    sh_t s_d, s_q;
    logic tick;

    assign tick = s_q.active && (s_q.dcnt == DW'(CLK_DIV - 1));

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.active = 1'b1;
            s_d.sclk   = 1'b0;
            s_d.dcnt   = '0;
            s_d.bcnt   = '0;
            s_d.tx_sh  = tx_byte;
        end else if (s_q.active) begin
            if (tick) begin
                s_d.dcnt = '0;
                if (!s_q.sclk) begin
                    s_d.sclk  = 1'b1;
                    s_d.rx_sh = {s_q.rx_sh[6:0], miso};
                end else begin
                    s_d.sclk = 1'b0;
                    if (s_q.bcnt == 3'd7) begin
                        s_d.active = 1'b0;
                    end else begin
                        s_d.bcnt  = s_q.bcnt + 3'd1;
                        s_d.tx_sh = {s_q.tx_sh[6:0], 1'b0};
                    end
                end
            end else begin
                s_d.dcnt = s_q.dcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sclk    = s_q.sclk;
    assign mosi    = s_q.active ? s_q.tx_sh[7] : 1'b0;
    assign done    = tick && s_q.sclk && (s_q.bcnt == 3'd7);
    assign rx_byte = s_q.rx_sh;

    // R11: clock idles low outside a byte
    a_r11_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active |-> !sclk)
        else $error("serial clock high while idle");

    // R2: data line held while the clock is high
    a_r2_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi))
        else $error("mosi moved during high clock");
endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
    import spi_eng_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go,
    input  logic [5:0]                    ctrl,
    input  logic [7:0]                    cmd,
    input  logic [8*ADDR_BYTES-1:0]       addr,
    input  logic [8*DATA_BYTES-1:0]       db,
    input  logic                          byte_done,
    output logic                          busy,
    output logic                          byte_start,
    output logic [7:0]                    tx_byte,
    output logic                          rx_we,
    output logic [$clog2(DATA_BYTES)-1:0] rx_idx
);
    localparam int WW    = $clog2(2 * CLK_DIV) > 0 ? $clog2(2 * CLK_DIV) : 1;
    localparam int IW    = $clog2(FRAME_BYTES);
    localparam int RXW   = $clog2(DATA_BYTES);
    localparam int DFIRST = 1 + ADDR_BYTES;

    typedef struct packed {
        seq_state_e    st;
        logic [WW-1:0] wcnt;
        logic [IW-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;
    logic [FRAME_BYTES-1:0] mask;
    logic [IW:0] nxt;
    logic wdone;
    int unsigned nbytes;

    function automatic logic [IW:0] pick_next(input logic [FRAME_BYTES-1:0] m, input int from);
        logic [IW:0] r;
        r = '0;
        for (int i = FRAME_BYTES - 1; i >= 0; i--)
            if (i >= from && m[i]) r = {1'b1, IW'(i)};
        return r;
    endfunction

    always_comb begin
        nbytes = (int'(ctrl[CNT_W-1:0]) > DATA_BYTES) ? DATA_BYTES : int'(ctrl[CNT_W-1:0]);
        mask[0] = !ctrl[CB_NOCMD];
        for (int i = 0; i < ADDR_BYTES; i++) mask[1 + i] = ctrl[CB_ADDR];
        for (int k = 0; k < DATA_BYTES; k++) mask[DFIRST + k] = (k < nbytes);
    end

    assign wdone = (s_q.wcnt == WW'(2 * CLK_DIV - 1));

    always_comb begin
        s_d = s_q;
        nxt = '0;
        case (s_q.st)
            ST_IDLE: if (go) begin
                s_d.st   = ST_SETUP;
                s_d.wcnt = '0;
            end
            ST_SETUP: begin
                if (wdone) begin
                    nxt      = pick_next(mask, 0);
                    s_d.wcnt = '0;
                    s_d.idx  = nxt[IW-1:0];
                    s_d.st   = nxt[IW] ? ST_LAUNCH : ST_HOLD;
                end else begin
                    s_d.wcnt = s_q.wcnt + 1'b1;
                end
            end
            ST_LAUNCH: s_d.st = ST_WAIT;
            ST_WAIT: if (byte_done) begin
                nxt      = pick_next(mask, int'(s_q.idx) + 1);
                s_d.wcnt = '0;
                s_d.idx  = nxt[IW-1:0];
                s_d.st   = nxt[IW] ? ST_LAUNCH : ST_HOLD;
            end
            ST_HOLD: begin
                if (wdone) s_d.st = ST_IDLE;
                else       s_d.wcnt = s_q.wcnt + 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.wcnt <= '0;
            s_q.idx  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        tx_byte = 8'h00;
        if (s_q.idx == '0) tx_byte = cmd;
        for (int i = 1; i <= ADDR_BYTES; i++)
            if (int'(s_q.idx) == i) tx_byte = addr[8*(ADDR_BYTES-i) +: 8];
        for (int k = 0; k < DATA_BYTES; k++)
            if (int'(s_q.idx) == DFIRST + k && ctrl[CB_WRITE]) tx_byte = db[8*k +: 8];
    end

    assign busy       = (s_q.st != ST_IDLE);
    assign byte_start = (s_q.st == ST_LAUNCH);
    assign rx_we      = (s_q.st == ST_WAIT) && byte_done && !ctrl[CB_WRITE]
                        && (int'(s_q.idx) >= DFIRST);
    assign rx_idx     = RXW'(int'(s_q.idx) - DFIRST);

    // R1: a start leaves the block busy on the next cycle
    a_r1_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy)
        else $error("start did not raise busy");
endmodule

// File: rtl/spi_flash_engine.sv
module spi_flash_engine
    import spi_eng_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    localparam int RXW = $clog2(DATA_BYTES);

    logic                      busy, go, byte_start, byte_done, rx_we;
    logic [RXW-1:0]            rx_idx;
    logic [7:0]                rx_byte, tx_byte, cmd;
    logic [8*ADDR_BYTES-1:0]   addr;
    logic [8*DATA_BYTES-1:0]   db;
    logic [6:0]                ctrl;
    logic [NUM_CS-1:0]         xcs;

    spi_eng_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .busy(busy), .rx_we(rx_we), .rx_idx(rx_idx),
        .rx_byte(rx_byte), .go(go), .cmd_o(cmd), .addr_o(addr), .db_o(db),
        .ctrl_o(ctrl), .xcs_o(xcs)
    );

    spi_eng_seq #(.CLK_DIV(CLK_DIV)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .ctrl(ctrl[5:0]), .cmd(cmd),
        .addr(addr), .db(db), .byte_done(byte_done), .busy(busy),
        .byte_start(byte_start), .tx_byte(tx_byte), .rx_we(rx_we), .rx_idx(rx_idx)
    );

    spi_eng_shift #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(byte_start), .tx_byte(tx_byte),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .done(byte_done),
        .rx_byte(rx_byte)
    );

    generate
        for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
            assign spi_cs_n[g] = xcs[g] & ~(busy && (int'(ctrl[CB_DEV]) == g));
        end
    endgenerate

    // R11: serial clock pulses only inside a frame
    a_r11_sclk_framed: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> busy)
        else $error("serial clock outside frame");

    // R7: hardware drives at most one chip select
    a_r7_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (xcs == '1) |-> $onehot0(~spi_cs_n))
        else $error("two chip selects active");
endmodule

// File: tb/tb_spi_flash_engine.sv
`timescale 1ns/1ps
module tb_spi_flash_engine;
    localparam int DIV = 2;
    localparam logic [3:0] A_CMD = 4'h0, A_AD0 = 4'h1, A_DB0 = 4'h4, A_CTRL = 4'h8, A_XCS = 4'h9;

    logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    wire  [7:0] reg_rdata;
    wire        sclk, mosi, miso;
    wire  [1:0] cs_n;

    always #4 clk = ~clk;

    spi_flash_engine #(.CLK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(sclk),
        .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // flash-side monitor
    bit mlog [0:1023];
    bit rlog [0:1023];
    int total = 0, base = 0;
    int falls0 = 0, falls1 = 0, rises1 = 0;
    realtime t_fall0 = 0, t_fall1 = 0, t_last = 0, setup_ns = 0, hold_ns = 0;

    assign miso = rlog[total % 1024];

    always @(posedge sclk) begin
        if (total == base) setup_ns = $realtime - ((t_fall0 > t_fall1) ? t_fall0 : t_fall1);
        mlog[total % 1024] = mosi;
        total = total + 1;
    end
    always @(negedge sclk) t_last = $realtime;
    always @(negedge cs_n[0]) begin t_fall0 = $realtime; falls0++; end
    always @(negedge cs_n[1]) begin t_fall1 = $realtime; falls1++; end
    always @(posedge cs_n[0] or posedge cs_n[1]) hold_ns = $realtime - t_last;
    always @(posedge cs_n[1]) rises1++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int n = 0; n < 4000; n++) begin
            rd_reg(A_CTRL, v);
            if (!v[7]) return;
        end
        chk("R1", 32'd1, 32'd0);
    endtask

    task automatic run_txn(input bit dev, input bit wr, input bit skip, input bit aen,
                           input logic [2:0] cnt, input logic [7:0] cmd,
                           input logic [23:0] ad, input logic [31:0] dbv,
                           input logic [7:0] seed, input bit burst);
        logic [7:0] resp [8];
        logic [7:0] exp  [8];
        logic [7:0] v, got;
        int nb, nd, dfirst, f0, f1;
        nd = (cnt > 4) ? 4 : int'(cnt);
        dfirst = (skip ? 0 : 1) + (aen ? 3 : 0);
        nb = dfirst + nd;
        wr_reg(A_CMD, cmd);
        for (int i = 0; i < 3; i++) wr_reg(A_AD0 + 4'(i), ad[8*i +: 8]);
        for (int k = 0; k < 4; k++) wr_reg(A_DB0 + 4'(k), dbv[8*k +: 8]);
        for (int p = 0; p < 8; p++) begin
            resp[p] = 8'h5A ^ 8'(p * 29) ^ seed;
            for (int b = 0; b < 8; b++) rlog[(total + 8*p + b) % 1024] = resp[p][7-b];
        end
        begin
            int e;
            e = 0;
            if (!skip) begin exp[e] = cmd; e++; end
            if (aen) begin
                exp[e] = ad[23:16]; exp[e+1] = ad[15:8]; exp[e+2] = ad[7:0]; e += 3;
            end
            for (int k = 0; k < nd; k++) begin exp[e] = wr ? dbv[8*k +: 8] : 8'h00; e++; end
        end
        base = total; f0 = falls0; f1 = falls1;
        wr_reg(A_CTRL, {1'b1, dev, wr, skip, aen, cnt});
        wait_idle();
        chk("R5 bit count", 32'(total - base), 32'(8 * nb));
        for (int p = 0; p < nb; p++) begin
            for (int b = 0; b < 8; b++) got[7-b] = mlog[(base + 8*p + b) % 1024];
            if (p < (skip ? 0 : 1))  chk("R3 command byte", 32'(got), 32'(exp[p]));
            else if (p < dfirst)     chk("R4 address byte", 32'(got), 32'(exp[p]));
            else                     chk("R6 data out", 32'(got), 32'(exp[p]));
        end
        if (!wr) for (int k = 0; k < nd; k++) begin
            rd_reg(A_DB0 + 4'(k), v);
            chk("R6 data in", 32'(v), 32'(resp[dfirst + k]));
        end
        rd_reg(A_CTRL, v);
        chk("R1 ctrl readback", 32'(v), 32'({1'b0, dev, wr, skip, aen, cnt}));
        if (!burst) begin
            chk("R7 device select", 32'((falls1 - f1) * 16 + (falls0 - f0)), dev ? 32'd16 : 32'd1);
            if (nb > 0) begin
                chk("R11 cs setup", 32'(setup_ns >= 16.0 * DIV), 32'd1);
                chk("R11 cs hold",  32'(hold_ns  >= 16.0 * DIV), 32'd1);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int r1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        for (int a = 0; a < 10; a++) begin
            rd_reg(4'(a), v);
            chk("R12 reset reg", 32'(v), (a == 9) ? 32'h03 : 32'h00);
        end
        chk("R12 reset pins", 32'({cs_n, sclk}), 32'b110);

        // sweep of every phase/direction/count/device combination
        for (int dv = 0; dv < 2; dv++)
            for (int w = 0; w < 2; w++)
                for (int s = 0; s < 2; s++)
                    for (int a = 0; a < 2; a++)
                        for (int c = 0; c < 8; c++)
                            run_txn(dv[0], w[0], s[0], a[0], 3'(c), 8'(8'h90 + c),
                                    24'(24'h3A5C71 + 1000 * c), 32'hC3A5_6E19 ^ 32'(c * 77),
                                    8'(dv * 64 + w * 32 + s * 16 + a * 8 + c), 1'b0);

        // R10, R9: reads and control writes during a frame
        wr_reg(A_DB0, 8'hA5);
        base = total;
        wr_reg(A_CTRL, 8'hAC);
        rd_reg(A_DB0, v);
        chk("R10 data read while busy", 32'(v), 32'h00);
        rd_reg(A_CTRL, v);
        chk("R1 busy bit set", 32'(v[7]), 32'd1);
        wr_reg(A_CTRL, 8'hFF);
        wait_idle();
        rd_reg(A_CTRL, v);
        chk("R9 ctrl unchanged", 32'(v), 32'h2C);
        repeat (100) @(negedge clk);
        chk("R9 no second frame", 32'(total - base), 32'd64);
        rd_reg(A_DB0, v);
        chk("R10 data read when idle", 32'(v), 32'hA5);

        // R8 burst on device 1
        wr_reg(A_XCS, 8'h01);
        chk("R8 override low", 32'(cs_n), 32'b01);
        r1 = rises1;
        run_txn(1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 8'h02, 24'h001200, 32'h0, 8'h11, 1'b1);
        for (int i = 0; i < 3; i++) begin
            run_txn(1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 8'(8'h40 + 3 * i), 24'h0, 32'h0, 8'h22, 1'b1);
            chk("R8 cs held in burst", 32'(cs_n[1]), 32'd0);
        end
        chk("R8 no release in burst", 32'(rises1 - r1), 32'd0);
        wr_reg(A_XCS, 8'h03);
        chk("R8 release", 32'(cs_n), 32'b11);
        wr_reg(A_XCS, 8'h02);
        chk("R8 override device 0", 32'(cs_n), 32'b10);
        wr_reg(A_XCS, 8'h03);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule